// File: doc/BRIEF.md
# PHY Reset and Receive-PLL Lock Sequencer

This block runs the bring-up sequence of a serial PHY: it resets the PHY and then confirms that the receive PLL has locked. It does not toggle the PHY's register handshake wires itself. Instead it issues commands to a separate handshake engine: address-capture, data-write and read. The engine answers each awaited command with a response pulse that carries a timeout flag and read data.

A single `go` pulse starts the sequence. The sequencer first selects the clock/reset register at address 0x7F3F and writes 0x0001 to it. Because that write resets the PHY, the PHY cannot acknowledge it, so the write is posted. The sequencer then polls the lane status register at 0x2003. Before each poll it waits a programmable interval, then it sends the address again and reads the register. A read with the lock bit set ends the sequence with `done`. Ten reads without lock end it with `err_lock`. A timeout on any awaited response ends it at once with `err_hs`. The outcome flag holds until the next `go`.

Top module: `phy_lock_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is 0.
- R2: A `go` pulse sampled while idle makes the following cycle carry an address command (`cmd_op`=01, `cmd_data`=0x7F3F) with `busy`=1, and it clears `done`, `err_hs` and `err_lock`.
- R3: Each command is a one-cycle `cmd_valid` pulse. While `cmd_valid` is 0, `cmd_op`, `cmd_data` and `cmd_posted` are 0. A `rsp_valid` pulse is acted on only while an address or read response is awaited, and is ignored at any other time.
- R4: One cycle after an error-free response to the 0x7F3F address, a write command is issued (`cmd_op`=10, `cmd_data`=0x0001, `cmd_posted`=1). No response is awaited for it.
- R5: An address command with `cmd_data`=0x2003 is issued WAIT_CYCLES cycles after the write pulse, and WAIT_CYCLES cycles after the cycle that follows a read response without lock.
- R6: One cycle after an error-free response to the 0x2003 address, a read command is issued (`cmd_op`=11, `cmd_data`=0). Data returned with an address response is ignored.
- R7: An error-free read response whose `rsp_data` has bit 1 set (LOCK_MASK=0x0002) makes `done`=1 and `busy`=0 in the next cycle. The other data bits have no effect.
- R8: If the tenth read response still shows no lock, the next cycle has `err_lock`=1 and `busy`=0, and no further command is issued.
- R9: A response with `rsp_timeout`=1 to an awaited address or read command makes `err_hs`=1 and `busy`=0 in the next cycle, and no further command is issued.
- R10: The outcome flags stay unchanged until the next `go` accepted while idle. A `go` pulse while `busy`=1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse |
| cmd_valid | output | 1 | One-cycle command strobe to the handshake engine |
| cmd_op | output | 2 | Command kind: 01 address, 10 write, 11 read |
| cmd_data | output | 16 | Address or write value; 0 for reads |
| cmd_posted | output | 1 | Command expects no response |
| rsp_valid | input | 1 | Response strobe from the handshake engine |
| rsp_timeout | input | 1 | Response reports a handshake timeout |
| rsp_data | input | 16 | Read data returned with a response |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | PLL lock confirmed |
| err_hs | output | 1 | Aborted on a handshake timeout |
| err_lock | output | 1 | PLL did not lock within ten polls |

## Verification
Every result is registered, so each one appears in the cycle after the edge that samples its cause. A command follows one cycle after `go` or after the response it depends on, and the outcome flags follow one cycle after the deciding response. The only exception is the poll address, which appears WAIT_CYCLES cycles after the write pulse or after the cycle that follows a failed read. The bench advances a behavioural model at each falling edge using the inputs the design has just sampled, then compares every output with it in that same cycle, so an early or late pulse fails at once. An engine model in the bench varies the response latency, the timeout position, the lock poll and the data noise. It also sends a stray response while no response is awaited.

// File: rtl/physeq_pkg.sv
package physeq_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_ADDR  = 2'b01,
        OP_WRITE = 2'b10,
        OP_READ  = 2'b11
    } hs_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_ADDR,
        ST_SETTLE,
        ST_STAT_ADDR,
        ST_STAT_READ
    } seq_state_e;

endpackage

// File: rtl/seq_interval_timer.sv
module seq_interval_timer #(
    parameter int unsigned WAIT_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CW = $clog2(WAIT_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          active;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.cnt    = CW'(WAIT_CYCLES - 1);
            tmr_d.active = 1'b1;
        end else if (tmr_q.active) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.active = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired = tmr_q.active && (tmr_q.cnt == '0);

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tmr_q.cnt) < WAIT_CYCLES); // R5

    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (tmr_q.active && !expired) || (WAIT_CYCLES == 1)); // R5

endmodule

// File: rtl/seq_poll_counter.sv
module seq_poll_counter #(
    parameter int unsigned MAX_POLLS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last
);
    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (bump) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == PW'(MAX_POLLS - 1));

    AST_POLL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        bump |-> (32'(cnt_q) < MAX_POLLS - 1)); // R8

endmodule

// File: rtl/phy_lock_sequencer.sv
module phy_lock_sequencer
    import physeq_pkg::*;
#(
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned WAIT_CYCLES   = 200,
    parameter int unsigned MAX_POLLS     = 10,
    parameter logic [15:0] RST_REG_ADDR  = 16'h7F3F,
    parameter logic [15:0] RST_VALUE     = 16'h0001,
    parameter logic [15:0] STAT_REG_ADDR = 16'h2003,
    parameter logic [15:0] LOCK_MASK     = 16'h0002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [DATA_W-1:0] cmd_data,
    output logic              cmd_posted,
    input  logic              rsp_valid,
    input  logic              rsp_timeout,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              busy,
    output logic              done,
    output logic              err_hs,
    output logic              err_lock
);
    localparam logic [DATA_W-1:0] RST_ADDR_W = DATA_W'(RST_REG_ADDR);
    localparam logic [DATA_W-1:0] RST_VAL_W  = DATA_W'(RST_VALUE);
    localparam logic [DATA_W-1:0] STAT_W     = DATA_W'(STAT_REG_ADDR);
    localparam logic [DATA_W-1:0] MASK_W     = DATA_W'(LOCK_MASK);

    typedef struct packed {
        seq_state_e        st;
        logic              cv;
        hs_op_e            op;
        logic [DATA_W-1:0] dat;
        logic              posted;
        logic              busy;
        logic              done;
        logic              ehs;
        logic              elock;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic timer_start;
    logic timer_expired;
    logic poll_clear;
    logic poll_bump;
    logic poll_last;
    logic lock_seen;

    assign lock_seen = |(rsp_data & MASK_W);

    seq_interval_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (timer_start),
        .expired (timer_expired)
    );

    seq_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_polls (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (poll_clear),
        .bump  (poll_bump),
        .last  (poll_last)
    );

    always_comb begin
        r_d         = r_q;
        r_d.cv      = 1'b0;
        r_d.op      = OP_NONE;
        r_d.dat     = '0;
        r_d.posted  = 1'b0;
        timer_start = 1'b0;
        poll_clear  = 1'b0;
        poll_bump   = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (go) begin
                    r_d.busy   = 1'b1;
                    r_d.done   = 1'b0;
                    r_d.ehs    = 1'b0;
                    r_d.elock  = 1'b0;
                    r_d.cv     = 1'b1;
                    r_d.op     = OP_ADDR;
                    r_d.dat    = RST_ADDR_W;
                    r_d.st     = ST_RST_ADDR;
                    poll_clear = 1'b1;
                end
            end
            ST_RST_ADDR: begin
                if (rsp_valid) begin
                    if (rsp_timeout) begin
                        r_d.st   = ST_IDLE;
                        r_d.busy = 1'b0;
                        r_d.ehs  = 1'b1;
                    end else begin
                        r_d.cv      = 1'b1;
                        r_d.op      = OP_WRITE;
                        r_d.dat     = RST_VAL_W;
                        r_d.posted  = 1'b1;
                        r_d.st      = ST_SETTLE;
                        timer_start = 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (timer_expired) begin
                    r_d.cv  = 1'b1;
                    r_d.op  = OP_ADDR;
                    r_d.dat = STAT_W;
                    r_d.st  = ST_STAT_ADDR;
                end
            end
            ST_STAT_ADDR: begin
                if (rsp_valid) begin
                    if (rsp_timeout) begin
                        r_d.st   = ST_IDLE;
                        r_d.busy = 1'b0;
                        r_d.ehs  = 1'b1;
                    end else begin
                        r_d.cv = 1'b1;
                        r_d.op = OP_READ;
                        r_d.st = ST_STAT_READ;
                    end
                end
            end
            ST_STAT_READ: begin
                if (rsp_valid) begin
                    if (rsp_timeout) begin
                        r_d.st   = ST_IDLE;
                        r_d.busy = 1'b0;
                        r_d.ehs  = 1'b1;
                    end else if (lock_seen) begin
                        r_d.st   = ST_IDLE;
                        r_d.busy = 1'b0;
                        r_d.done = 1'b1;
                    end else if (poll_last) begin
                        r_d.st    = ST_IDLE;
                        r_d.busy  = 1'b0;
                        r_d.elock = 1'b1;
                    end else begin
                        poll_bump   = 1'b1;
                        timer_start = 1'b1;
                        r_d.st      = ST_SETTLE;
                    end
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_valid  = r_q.cv;
    assign cmd_op     = r_q.op;
    assign cmd_data   = r_q.dat;
    assign cmd_posted = r_q.posted;
    assign busy       = r_q.busy;
    assign done       = r_q.done;
    assign err_hs     = r_q.ehs;
    assign err_lock   = r_q.elock;

    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R3

    AST_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy); // R3

    AST_WRITE_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WRITE) |-> (cmd_posted && cmd_data == RST_VAL_W)); // R4

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_hs, err_lock})); // R7

    AST_NO_FLAG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(done || err_hs || err_lock)); // R10

    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((done || err_hs || err_lock) && !go) |=> $stable({done, err_hs, err_lock})); // R10

    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_hs) |-> !cmd_valid); // R9

endmodule

// File: tb/phy_lock_sequencer_test.sv
module phy_lock_sequencer_test;
    localparam int W = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [15:0] cmd_data;
    logic        cmd_posted;
    logic        rsp_valid = 1'b0;
    logic        rsp_timeout = 1'b0;
    logic [15:0] rsp_data = '0;
    logic        busy, done, err_hs, err_lock;

    always #2 clk = ~clk;

    phy_lock_sequencer #(.WAIT_CYCLES(W)) uut (
        .clk(clk), .rst_n(rst_n), .go(go),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_posted(cmd_posted),
        .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_data(rsp_data),
        .busy(busy), .done(done), .err_hs(err_hs), .err_lock(err_lock)
    );

    int total = 0;
    int bad = 0;

    // behavioural reference
    int    m_phase = 0;
    int    m_left = 0;
    int    m_polls = 0;
    bit    m_cv = 0, m_post = 0, m_busy = 0, m_done = 0, m_ehs = 0, m_elk = 0;
    int    m_op = 0;
    int    m_dat = 0;
    string m_tag = "R3";

    // engine model
    int cfg_lat = 1, cfg_to_idx = -1, cfg_lock_at = 0;
    bit cfg_noise = 0, cfg_spur = 0;
    int resp_cnt = -1, np_idx = 0, reads = 0;
    bit pend_to = 0, spur_pending = 0;
    logic [15:0] pend_data = '0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input int op, input int dat, input bit post, input string tag);
        m_cv = 1; m_op = op; m_dat = dat; m_post = post; m_tag = tag;
    endtask

    task automatic fail_hs();
        m_phase = 0; m_busy = 0; m_ehs = 1;
    endtask

    task automatic model_step();
        if (!rst_n) begin
            m_phase = 0; m_cv = 0; m_op = 0; m_dat = 0; m_post = 0;
            m_busy = 0; m_done = 0; m_ehs = 0; m_elk = 0; m_tag = "R1";
            return;
        end
        m_cv = 0; m_op = 0; m_dat = 0; m_post = 0; m_tag = "R3";
        case (m_phase)
            0: if (go) begin
                m_busy = 1; m_done = 0; m_ehs = 0; m_elk = 0; m_polls = 0;
                issue(1, 16'h7F3F, 0, "R2"); m_phase = 1;
            end
            1: if (rsp_valid) begin
                if (rsp_timeout) fail_hs();
                else begin issue(2, 16'h0001, 1, "R4"); m_phase = 2; m_left = W; end
            end
            2: begin
                m_left--;
                if (m_left == 0) begin issue(1, 16'h2003, 0, "R5"); m_phase = 3; end
            end
            3: if (rsp_valid) begin
                if (rsp_timeout) fail_hs();
                else begin issue(3, 0, 0, "R6"); m_phase = 4; end
            end
            default: if (rsp_valid) begin
                if (rsp_timeout) fail_hs();
                else if (rsp_data[1]) begin m_phase = 0; m_busy = 0; m_done = 1; end
                else begin
                    m_polls++;
                    if (m_polls == 10) begin m_phase = 0; m_busy = 0; m_elk = 1; end
                    else begin m_phase = 2; m_left = W; end
                end
            end
        endcase
    endtask

    task automatic compare();
        string t;
        t = rst_n ? m_tag : "R1";
        check(cmd_valid === m_cv, t, "cmd_valid", int'(cmd_valid), int'(m_cv));
        check(cmd_op === 2'(m_op), t, "cmd_op", int'(cmd_op), m_op);
        check(cmd_data === 16'(m_dat), t, "cmd_data", int'(cmd_data), m_dat);
        check(cmd_posted === m_post, t, "cmd_posted", int'(cmd_posted), int'(m_post));
        check(busy === m_busy, rst_n ? "R10" : "R1", "busy", int'(busy), int'(m_busy));
        check(done === m_done, rst_n ? "R7" : "R1", "done", int'(done), int'(m_done));
        check(err_hs === m_ehs, rst_n ? "R9" : "R1", "err_hs", int'(err_hs), int'(m_ehs));
        check(err_lock === m_elk, rst_n ? "R8" : "R1", "err_lock", int'(err_lock), int'(m_elk));
    endtask

    task automatic tick();
        @(negedge clk);
        model_step();
        compare();
        go = 1'b0;
        rsp_valid = 1'b0; rsp_timeout = 1'b0; rsp_data = '0;
        if (resp_cnt > 0) resp_cnt--;
        if (resp_cnt == 0) begin
            rsp_valid = 1'b1; rsp_timeout = pend_to; rsp_data = pend_data; resp_cnt = -1;
        end
        if (spur_pending) begin
            rsp_valid = 1'b1; rsp_timeout = 1'b1; spur_pending = 0;
        end
        if (cmd_valid === 1'b1) begin
            if (cmd_posted) begin
                if (cfg_spur) spur_pending = 1;
            end else begin
                pend_to = (np_idx == cfg_to_idx);
                if (cmd_op == 2'b11) begin
                    reads++;
                    pend_data = (reads == cfg_lock_at) ? 16'h0002 :
                                (cfg_noise ? 16'hFFFD : 16'h0000);
                end else begin
                    pend_data = cfg_noise ? 16'hFFFF : 16'h0000;  // R6 address data ignored
                end
                np_idx++;
                resp_cnt = cfg_lat;
            end
        end
    endtask

    // outcome: 0 done, 1 handshake error, 2 lock timeout
    task automatic run(input int lat, input int to_idx, input int lock_at, input bit noise,
                       input bit spur, input bit busy_go, input int outcome, input int exp_reads);
        cfg_lat = lat; cfg_to_idx = to_idx; cfg_lock_at = lock_at;
        cfg_noise = noise; cfg_spur = spur;
        resp_cnt = -1; np_idx = 0; reads = 0; spur_pending = 0;
        go = 1'b1;
        tick();
        for (int i = 0; i < 3000 && m_busy; i++) begin
            if (busy_go && i == 3) go = 1'b1;  // R10 go while busy
            tick();
        end
        case (outcome)
            0: check(done === 1'b1, "R7", "outcome done", int'(done), 1);
            1: check(err_hs === 1'b1, "R9", "outcome err_hs", int'(err_hs), 1);
            default: check(err_lock === 1'b1, "R8", "outcome err_lock", int'(err_lock), 1);
        endcase
        check(reads == exp_reads, outcome == 2 ? "R8" : "R5", "read count", reads, exp_reads);
        for (int i = 0; i < 6; i++) tick();
        check(busy === 1'b0, "R10", "idle after run", int'(busy), 0);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1'b1;
        tick();
        check({cmd_valid, busy, done, err_hs, err_lock} === 5'b0, "R1", "post reset",
              int'({cmd_valid, busy, done, err_hs, err_lock}), 0);
        run(1, -1, 1, 0, 0, 0, 0, 1);
        run(3, -1, 3, 1, 0, 0, 0, 3);
        run(2, -1, 10, 1, 0, 0, 0, 10);
        run(1, -1, 0, 1, 0, 0, 2, 10);
        run(1, 0, 1, 0, 0, 0, 1, 0);
        run(2, 1, 1, 0, 0, 0, 1, 0);
        run(1, 2, 1, 0, 0, 0, 1, 1);
        run(1, 7, 0, 0, 0, 0, 1, 3);
        run(1, -1, 2, 0, 1, 1, 0, 2);
        run(4, -1, 1, 1, 0, 0, 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule